// File: doc/BRIEF.md
# PLL Configuration and Clock-Failover Controller

This block is the control logic that sits beside a clock-multiplying PLL. It holds the PLL multiplier, a full-rate select bit and a PLL-off bit, all writable only while a protect-enable input is high. From those settings, from a PLL lock indication and from an oscillator-presence monitor it chooses which clock feeds the CPU: the oscillator at full rate, the oscillator halved, the PLL output, or a backup limp clock. The analog PLL, the oscillator and the glitch-free mux cells are outside the block; it only drives their select and enable pins.

The block is clocked by the always-running limp clock. The oscillator domain supplies a toggle flag (`osc_tgl`) that flips at a rate derived from the oscillator; the block synchronises it and checks that it keeps moving. Any change of the multiplier sends the CPU clock back to the bypass source until the PLL reports lock again, and the limp clock is only substituted once the oscillator has been seen alive at least once since reset.

Mode state machine (`pclk_fsm`): BYPASS (PLL running but not used), RELOCK (new multiplier written, waiting for lock), RUN (PLL output in use), OFF (PLL disabled). Transitions: BYPASS→RELOCK on an accepted nonzero multiplier; BYPASS→OFF when the PLL-off bit is set; RELOCK→RUN when the synchronised lock is seen high after having been seen low; RELOCK→BYPASS on an accepted zero multiplier; RELOCK→RELOCK (restart) on another nonzero multiplier; RUN→RELOCK on a nonzero multiplier or lock loss; RUN→BYPASS on a zero multiplier; OFF→BYPASS when the PLL-off bit is cleared. The oscillator monitor (`pclk_clkmon`) has two states, PRESENT and MISSING: PRESENT→MISSING at the end of any 16-cycle window without a toggle; MISSING→PRESENT after 4 consecutive windows that each held a toggle.

Top module: `pll_clk_ctrl`

## Requirements
- R1: After reset the multiplier is 0, `clk_sel` is 2'b01 (oscillator halved), `pll_en` is 1, and `locked`, `full_rate`, `wr_err` and `limp_active` are 0.
- R2: A write with `wr_sel`=2'b00 loads `wr_data` as the multiplier; codes 0 to 10 are accepted, codes 11 to 15 are ignored (multiplier unchanged) and set `wr_err`.
- R3: A write with `wr_sel`=2'b01 loads `wr_data[0]` as the full-rate bit; setting it to 1 is accepted only while the multiplier is 0. While it is 1, every multiplier write is ignored and sets `wr_err`. With multiplier 0, `clk_sel` is 2'b00 when the bit is 1 and 2'b01 when it is 0.
- R4: A write with `wr_sel`=2'b10 loads `wr_data[0]` as the PLL-off bit; setting it is accepted only while the multiplier is 0. In PLL-off mode `pll_en` is 0, `clk_sel` is 2'b00 or 2'b01 per the full-rate bit, and nonzero multiplier writes are ignored and set `wr_err`. A rejected ordering write leaves all fields unchanged.
- R5: An accepted nonzero multiplier write keeps `clk_sel` at the bypass source and `locked` at 0 until `pll_lock` has passed the two-stage synchroniser low then high; the PLL source (2'b10) is then selected with `locked`=1. A zero multiplier write returns to bypass.
- R6: If `pll_lock` falls while the PLL source is in use, the block returns to the bypass source and waits for lock again.
- R7: Writes while `prot_en` is 0 change no field and do not set `wr_err`; `wr_sel`=2'b11 writes nothing.
- R8: `wr_err` is sticky; a cycle with `err_rd` high clears it, unless a new rejected write happens in that same cycle, in which case it stays 1.
- R9: `clk_missing` rises when a 16-cycle window passes without a synchronised toggle of `osc_tgl`, and falls after 4 consecutive windows that each saw a toggle.
- R10: `limp_active` is 1, and `clk_sel` is 2'b11, only when the oscillator is missing and has toggled at least once since reset; before the first toggle a missing oscillator does not select the limp clock.
- R11: In PLL-off mode a missing oscillator does not select the limp clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Limp clock, always running; clocks the whole block |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tgl | input | 1 | Toggle flag from the oscillator domain (asynchronous) |
| pll_lock | input | 1 | Lock indication from the PLL (asynchronous) |
| prot_en | input | 1 | Write-protect gate; writes take effect only while high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 00 multiplier, 01 full-rate bit, 10 PLL-off bit, 11 none |
| wr_data | input | 4 | Write data |
| err_rd | input | 1 | Read strobe for the error flag; clears it |
| clk_sel | output | 2 | CPU clock source: 00 osc, 01 osc/2, 10 PLL, 11 limp |
| pll_en | output | 1 | PLL enable |
| mult_o | output | 4 | Current multiplier |
| full_rate | output | 1 | Full-rate (undivided bypass) bit |
| locked | output | 1 | PLL output in use |
| limp_active | output | 1 | Limp clock substituted |
| clk_missing | output | 1 | Oscillator judged absent |
| wr_err | output | 1 | Sticky rejected-write flag |

## Verification
The hardest situation to reach is the interplay of failover with the mode machine: the limp clock must stay deselected while the oscillator has never toggled, then take over from a running PLL, then hand back the PLL source after recovery, and stay off in PLL-off mode. The bench drives an oscillator toggle model it can start and stop, holds it silent from reset to see the unarmed case, and waits whole monitor windows before sampling. Register ordering is covered by sweeping all sixteen multiplier codes from bypass, with the expected acceptance computed from the code, and by attempting each ordering-forbidden write from each mode.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    typedef enum logic [1:0] {
        SRC_OSC  = 2'b00,
        SRC_HALF = 2'b01,
        SRC_PLL  = 2'b10,
        SRC_LIMP = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        MD_BYPASS,
        MD_RELOCK,
        MD_RUN,
        MD_OFF
    } mode_e;

    typedef enum logic [1:0] {
        WR_MULT = 2'b00,
        WR_DIV  = 2'b01,
        WR_OFF  = 2'b10,
        WR_NONE = 2'b11
    } wr_tgt_e;

    typedef enum logic {
        MON_PRESENT,
        MON_MISSING
    } mon_e;

endpackage

// File: rtl/pclk_sync.sv
module pclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pclk_regs.sv
module pclk_regs
    import pclk_pkg::*;
#(
    parameter int MULT_W   = 4,
    parameter int MULT_MAX = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              prot_en,
    input  wr_tgt_e           wr_tgt,
    input  logic [MULT_W-1:0] wr_data,
    input  logic              err_rd,
    output logic [MULT_W-1:0] mult_q,
    output logic              div_q,
    output logic              off_q,
    output logic              mult_acc,
    output logic              err_q
);
    localparam logic [MULT_W-1:0] MAX_CODE = MULT_W'(MULT_MAX);

    logic wr_live;
    logic div_acc;
    logic off_acc;
    logic bad_wr;
    logic data_zero;

    assign wr_live   = wr_en && prot_en;
    assign data_zero = (wr_data == '0);

    always_comb begin
        mult_acc = 1'b0;
        div_acc  = 1'b0;
        off_acc  = 1'b0;
        bad_wr   = 1'b0;
        if (wr_live) begin
            unique case (wr_tgt)
                WR_MULT: begin
                    if (wr_data > MAX_CODE || div_q || (off_q && !data_zero))
                        bad_wr = 1'b1;
                    else
                        mult_acc = 1'b1;
                end
                WR_DIV: begin
                    if (wr_data[0] && mult_q != '0) bad_wr  = 1'b1;
                    else                            div_acc = 1'b1;
                end
                WR_OFF: begin
                    if (wr_data[0] && mult_q != '0) bad_wr  = 1'b1;
                    else                            off_acc = 1'b1;
                end
                WR_NONE: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mult_q <= '0;
            div_q  <= 1'b0;
            off_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (mult_acc) mult_q <= wr_data;
            if (div_acc)  div_q  <= wr_data[0];
            if (off_acc)  off_q  <= wr_data[0];
            if (bad_wr)       err_q <= 1'b1;
            else if (err_rd)  err_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pclk_clkmon.sv
module pclk_clkmon
    import pclk_pkg::*;
#(
    parameter int SYNC_N = 2,
    parameter int WIN    = 16,
    parameter int REC    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tgl,
    output logic armed,
    output logic missing
);
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int GW = $clog2(REC + 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(WIN - 1);
    localparam logic [GW-1:0] REC_LAST = GW'(REC - 1);

    mon_e          state, state_nx;
    logic          tgl_s, tgl_prev, tgl_edge;
    logic [CW-1:0] win_cnt;
    logic [GW-1:0] good_cnt, good_nx;
    logic          seen;
    logic          win_end, hit;

    pclk_sync #(.STAGES(SYNC_N)) u_tgl_sync (
        .clk(clk), .rst_n(rst_n), .d(osc_tgl), .q(tgl_s)
    );

    assign tgl_edge = tgl_s ^ tgl_prev;
    assign win_end  = (win_cnt == WIN_LAST);
    assign hit      = seen || tgl_edge;

    always_comb begin
        state_nx = state;
        good_nx  = good_cnt;
        if (win_end) begin
            unique case (state)
                MON_PRESENT: begin
                    if (!hit) state_nx = MON_MISSING;
                    good_nx = '0;
                end
                MON_MISSING: begin
                    if (!hit) begin
                        good_nx = '0;
                    end else if (good_cnt == REC_LAST) begin
                        state_nx = MON_PRESENT;
                        good_nx  = '0;
                    end else begin
                        good_nx = good_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= MON_PRESENT;
            good_cnt <= '0;
            win_cnt  <= '0;
            seen     <= 1'b0;
            tgl_prev <= 1'b0;
            armed    <= 1'b0;
        end else begin
            state    <= state_nx;
            good_cnt <= good_nx;
            tgl_prev <= tgl_s;
            if (tgl_edge) armed <= 1'b1;
            if (win_end) begin
                win_cnt <= '0;
                seen    <= 1'b0;
            end else begin
                win_cnt <= win_cnt + 1'b1;
                seen    <= hit;
            end
        end
    end

    always_comb missing = (state == MON_MISSING);
endmodule

// File: rtl/pclk_fsm.sv
module pclk_fsm
    import pclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mult_acc,
    input  logic  new_zero,
    input  logic  div_q,
    input  logic  off_q,
    input  logic  lock_s,
    input  logic  limp_req,
    output src_e  clk_sel,
    output logic  pll_en,
    output logic  locked,
    output logic  limp_active
);
    mode_e mode, mode_nx;
    logic  wait_low, wait_nx;

    always_comb begin
        mode_nx = mode;
        unique case (mode)
            MD_BYPASS: begin
                if (mult_acc && !new_zero) mode_nx = MD_RELOCK;
                else if (off_q)            mode_nx = MD_OFF;
            end
            MD_RELOCK: begin
                if (mult_acc)                mode_nx = new_zero ? MD_BYPASS : MD_RELOCK;
                else if (!wait_low && lock_s) mode_nx = MD_RUN;
            end
            MD_RUN: begin
                if (mult_acc)     mode_nx = new_zero ? MD_BYPASS : MD_RELOCK;
                else if (!lock_s) mode_nx = MD_RELOCK;
            end
            MD_OFF: begin
                if (!off_q) mode_nx = MD_BYPASS;
            end
        endcase
    end

    always_comb begin
        if (mode_nx == MD_RELOCK && (mode != MD_RELOCK || mult_acc))
            wait_nx = 1'b1;
        else if (!lock_s)
            wait_nx = 1'b0;
        else
            wait_nx = wait_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode     <= MD_BYPASS;
            wait_low <= 1'b0;
        end else begin
            mode     <= mode_nx;
            wait_low <= wait_nx;
        end
    end

    always_comb begin
        limp_active = limp_req && (mode != MD_OFF);
        pll_en      = (mode != MD_OFF);
        locked      = (mode == MD_RUN);
        if (limp_active)        clk_sel = SRC_LIMP;
        else if (mode == MD_RUN) clk_sel = SRC_PLL;
        else if (div_q)         clk_sel = SRC_OSC;
        else                    clk_sel = SRC_HALF;
    end
endmodule

// File: rtl/pll_clk_ctrl.sv
module pll_clk_ctrl
    import pclk_pkg::*;
#(
    parameter int MULT_W   = 4,
    parameter int MULT_MAX = 10,
    parameter int SYNC_N   = 2,
    parameter int WIN      = 16,
    parameter int REC      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tgl,
    input  logic              pll_lock,
    input  logic              prot_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [MULT_W-1:0] wr_data,
    input  logic              err_rd,
    output logic [1:0]        clk_sel,
    output logic              pll_en,
    output logic [MULT_W-1:0] mult_o,
    output logic              full_rate,
    output logic              locked,
    output logic              limp_active,
    output logic              clk_missing,
    output logic              wr_err
);
    logic mult_acc, div_q, off_q, lock_s, armed, missing;
    src_e sel_e;

    pclk_sync #(.STAGES(SYNC_N)) u_lock_sync (
        .clk(clk), .rst_n(rst_n), .d(pll_lock), .q(lock_s)
    );

    pclk_regs #(.MULT_W(MULT_W), .MULT_MAX(MULT_MAX)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .prot_en(prot_en),
        .wr_tgt(wr_tgt_e'(wr_sel)), .wr_data(wr_data), .err_rd(err_rd),
        .mult_q(mult_o), .div_q(div_q), .off_q(off_q),
        .mult_acc(mult_acc), .err_q(wr_err)
    );

    pclk_clkmon #(.SYNC_N(SYNC_N), .WIN(WIN), .REC(REC)) u_mon (
        .clk(clk), .rst_n(rst_n), .osc_tgl(osc_tgl),
        .armed(armed), .missing(missing)
    );

    pclk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mult_acc(mult_acc),
        .new_zero(wr_data == '0), .div_q(div_q), .off_q(off_q),
        .lock_s(lock_s), .limp_req(armed && missing),
        .clk_sel(sel_e), .pll_en(pll_en), .locked(locked),
        .limp_active(limp_active)
    );

    assign clk_sel     = sel_e;
    assign full_rate   = div_q;
    assign clk_missing = missing;
endmodule

// File: rtl/pll_clk_ctrl_chk.sv
module pll_clk_ctrl_chk #(
    parameter int MULT_W   = 4,
    parameter int MULT_MAX = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pll_lock,
    input logic              prot_en,
    input logic              wr_en,
    input logic              err_rd,
    input logic [1:0]        clk_sel,
    input logic              pll_en,
    input logic [MULT_W-1:0] mult_o,
    input logic              full_rate,
    input logic              limp_active,
    input logic              clk_missing,
    input logic              wr_err
);
    AST_MULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mult_o <= MULT_W'(MULT_MAX)); // R2
    AST_FULL_RATE_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        full_rate |-> mult_o == '0); // R3
    AST_OFF_NO_PLL: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> (mult_o == '0 && clk_sel != 2'b10)); // R4
    AST_PLL_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_sel == 2'b10) |-> $past(pll_lock)); // R5
    AST_MULT_CHANGE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mult_o != $past(mult_o)) |-> clk_sel != 2'b10); // R5
    AST_UNPROT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !prot_en) |=> ($stable(mult_o) && $stable(full_rate))); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err && !err_rd) |=> wr_err); // R8
    AST_LIMP_NEEDS_MISSING: assert property (@(posedge clk) disable iff (!rst_n)
        limp_active |-> (clk_missing && clk_sel == 2'b11)); // R10
    AST_LIMP_NOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        limp_active |-> pll_en); // R11
endmodule

bind pll_clk_ctrl pll_clk_ctrl_chk #(.MULT_W(MULT_W), .MULT_MAX(MULT_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock), .prot_en(prot_en),
    .wr_en(wr_en), .err_rd(err_rd), .clk_sel(clk_sel), .pll_en(pll_en),
    .mult_o(mult_o), .full_rate(full_rate), .limp_active(limp_active),
    .clk_missing(clk_missing), .wr_err(wr_err)
);

// File: tb/pll_clk_ctrl_bench.sv
module pll_clk_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tgl = 1'b0;
    logic       pll_lock = 1'b0;
    logic       prot_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b11;
    logic [3:0] wr_data = 4'd0;
    logic       err_rd = 1'b0;
    logic [1:0] clk_sel;
    logic       pll_en, full_rate, locked, limp_active, clk_missing, wr_err;
    logic [3:0] mult_o;

    logic osc_run = 1'b0;
    int   tests = 0;
    int   fails = 0;

    always #4 clk = ~clk;

    pll_clk_ctrl u_pll_clk_ctrl (
        .clk(clk), .rst_n(rst_n), .osc_tgl(osc_tgl), .pll_lock(pll_lock),
        .prot_en(prot_en), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .err_rd(err_rd), .clk_sel(clk_sel), .pll_en(pll_en), .mult_o(mult_o),
        .full_rate(full_rate), .locked(locked), .limp_active(limp_active),
        .clk_missing(clk_missing), .wr_err(wr_err)
    );

    initial begin : osc_model
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            if (osc_run) begin
                ph++;
                if (ph >= 3) begin
                    osc_tgl = ~osc_tgl;
                    ph = 0;
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] d, input logic rd);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; err_rd = rd;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'b11; wr_data = 4'd0; err_rd = 1'b0;
    endtask

    task automatic clr_err();
        @(negedge clk);
        err_rd = 1'b1;
        @(negedge clk);
        err_rd = 1'b0;
    endtask

    // write a multiplier while the modelled PLL drops lock
    task automatic wr_mult(input logic [3:0] d);
        pll_lock = 1'b0;
        wr(2'b00, d, 1'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 mult", mult_o, 0);
        chk("R1 sel", clk_sel, 1);
        chk("R1 pll_en", pll_en, 1);
        chk("R1 locked", locked, 0);
        chk("R1 full_rate", full_rate, 0);
        chk("R1 wr_err", wr_err, 0);
        chk("R1 limp", limp_active, 0);

        // R10 oscillator never seen: missing but not armed
        tick(30);
        chk("R9 missing before first toggle", clk_missing, 1);
        chk("R10 unarmed no limp", limp_active, 0);
        chk("R10 unarmed sel", clk_sel, 1);

        osc_run = 1'b1;
        tick(120);
        chk("R9 recovered", clk_missing, 0);
        chk("R10 recovered sel", clk_sel, 1);

        // R2 sweep of every multiplier code from bypass
        for (int code = 0; code < 16; code++) begin
            bit ok;
            ok = (code <= 10);
            wr_mult(4'(code));
            chk("R2 mult value", mult_o, ok ? code : 0);
            chk("R2 err flag", wr_err, ok ? 0 : 1);
            if (ok && code != 0) begin
                tick(6);
                chk("R5 bypass until lock", clk_sel, 1);
                chk("R5 not locked", locked, 0);
                pll_lock = 1'b1;
                tick(4);
                chk("R5 pll selected", clk_sel, 2);
                chk("R5 locked", locked, 1);
            end
            clr_err();
            chk("R8 err cleared", wr_err, 0);
            wr_mult(4'd0);
            tick(1);
            chk("R5 zero back to bypass", clk_sel, 1);
        end

        // R5 change while running forces bypass
        wr_mult(4'd4);
        pll_lock = 1'b1;
        tick(4);
        chk("R5 run at 4", clk_sel, 2);
        wr_mult(4'd7);
        chk("R5 change goes bypass", clk_sel, 1);
        tick(5);
        chk("R5 still bypass", clk_sel, 1);
        pll_lock = 1'b1;
        tick(4);
        chk("R5 relocked", clk_sel, 2);
        chk("R5 mult 7", mult_o, 7);

        // R6 lock loss
        pll_lock = 1'b0;
        tick(4);
        chk("R6 lock loss bypass", clk_sel, 1);
        chk("R6 not locked", locked, 0);
        pll_lock = 1'b1;
        tick(4);
        chk("R6 lock regained", clk_sel, 2);

        // R3 full-rate bit rejected while multiplier nonzero
        wr(2'b01, 4'd1, 1'b0);
        chk("R3 div rejected", full_rate, 0);
        chk("R3 div err", wr_err, 1);
        chk("R3 sel kept pll", clk_sel, 2);
        clr_err();
        wr_mult(4'd0);
        wr(2'b01, 4'd1, 1'b0);
        chk("R3 div accepted", full_rate, 1);
        chk("R3 full rate sel", clk_sel, 0);
        wr_mult(4'd5);
        chk("R3 mult rejected", mult_o, 0);
        chk("R3 mult err", wr_err, 1);
        wr_mult(4'd0);
        chk("R3 zero also rejected", wr_err, 1);
        clr_err();

        // R8 new error in the same cycle as read keeps flag
        wr(2'b00, 4'd3, 1'b0);
        chk("R8 err set", wr_err, 1);
        wr(2'b00, 4'd3, 1'b1);
        chk("R8 set wins over clear", wr_err, 1);
        clr_err();
        wr(2'b01, 4'd0, 1'b0);
        chk("R3 div cleared", full_rate, 0);
        chk("R3 half sel", clk_sel, 1);

        // R7 protect gate and no-target writes
        prot_en = 1'b0;
        wr_mult(4'd6);
        chk("R7 mult unchanged", mult_o, 0);
        wr(2'b01, 4'd1, 1'b0);
        chk("R7 div unchanged", full_rate, 0);
        wr_mult(4'd13);
        chk("R7 no err", wr_err, 0);
        prot_en = 1'b1;
        wr(2'b11, 4'd9, 1'b0);
        chk("R7 none target mult", mult_o, 0);
        chk("R7 none target err", wr_err, 0);

        // R4 PLL-off ordering
        wr_mult(4'd2);
        pll_lock = 1'b1;
        tick(4);
        wr(2'b10, 4'd1, 1'b0);
        chk("R4 off rejected", pll_en, 1);
        chk("R4 off err", wr_err, 1);
        clr_err();
        wr_mult(4'd0);
        wr(2'b10, 4'd1, 1'b0);
        tick(2);
        chk("R4 pll disabled", pll_en, 0);
        chk("R4 off sel half", clk_sel, 1);
        wr_mult(4'd4);
        chk("R4 mult rejected", mult_o, 0);
        chk("R4 mult err", wr_err, 1);
        clr_err();
        wr(2'b01, 4'd1, 1'b0);
        chk("R4 off full rate sel", clk_sel, 0);

        // R11 no failover in PLL-off mode
        osc_run = 1'b0;
        tick(40);
        chk("R11 missing seen", clk_missing, 1);
        chk("R11 no limp", limp_active, 0);
        chk("R11 sel osc", clk_sel, 0);
        osc_run = 1'b1;
        tick(100);
        chk("R9 recovered again", clk_missing, 0);
        wr(2'b01, 4'd0, 1'b0);
        wr(2'b10, 4'd0, 1'b0);
        tick(2);
        chk("R4 pll re-enabled", pll_en, 1);

        // R10 failover from a running PLL
        wr_mult(4'd9);
        pll_lock = 1'b1;
        tick(4);
        chk("R10 pll before loss", clk_sel, 2);
        osc_run = 1'b0;
        tick(10);
        chk("R9 not yet missing", clk_missing, 0);
        tick(30);
        chk("R9 missing", clk_missing, 1);
        chk("R10 limp active", limp_active, 1);
        chk("R10 limp sel", clk_sel, 3);
        osc_run = 1'b1;
        tick(40);
        chk("R9 needs four windows", clk_missing, 1);
        tick(60);
        chk("R9 recovered", clk_missing, 0);
        chk("R10 back to pll", clk_sel, 2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule